// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serializes bytes onto a single asynchronous serial line. A one-entry holding register sits in front of the shift register, so the host can queue the next byte while the current frame is still going out. A write to the holding register starts a transmission. One system clock later the byte moves into the shift register. The frame then begins on the next active edge of the bit clock.

The bit clock is made from a baud-rate tick. A select input picks the tick source: either a one-cycle pulse from an internal timer, or the rising edges of an external clock pin after they pass through a synchronizer. A free-running counter divides the selected tick by 16 to give the bit rate. Buffer writes never realign this counter, so the delay from a write to the start bit varies.

The block has two separate status events. A buffer-empty pulse marks each move from the holding register into the shift register. A transmit-complete pulse marks the end of a frame only when no further byte is waiting. Frame length (7 or 8 data bits), parity enable and parity sense are sampled at the moment each frame is loaded.

Top module: `dbuf_uart_tx`

## Requirements
- R1: A synchronous reset drives `txd` to 1, clears the holding register and the divider, and keeps `buf_empty` and `tx_done` at 0. A frame cut short by reset is not resumed.
- R2: With `src_ext`=0 the divider counts `tick_int` pulses. With `src_ext`=1 it counts synchronized rising edges of `ext_clk` and ignores `tick_int`. Every bit on `txd` lasts exactly 16 counted ticks.
- R3: The start bit begins on the first divider wrap after the shift register is loaded. From an idle write, the start bit appears no sooner than 2 and no later than 16 ticks plus 1 clock after the write edge.
- R4: `buf_empty` is high for one clock in the cycle after the holding byte is copied into the shift register. When the block is idle, this is the second clock edge after the write.
- R5: A frame is a start bit of 0, then the data bits least significant first, then a parity bit when `cfg_par_en`=1, then a stop bit of 1. `cfg_len8`=1 sends 8 data bits and 0 sends 7, in which case `wr_data[7]` is not sent.
- R6: With `cfg_par_odd`=0 the parity bit makes the count of ones over data and parity even. With `cfg_par_odd`=1 it makes that count odd.
- R7: If a byte is waiting when a stop bit ends, its start bit follows at once with no idle time, `buf_empty` pulses in that cycle, and `tx_done` stays 0.
- R8: If nothing is waiting when a stop bit ends, `tx_done` is high for exactly one clock in the cycle after the stop bit ends, and `txd` stays 1.
- R9: A write to a full holding register replaces the pending byte. Only the last byte is sent.
- R10: Configuration changes made during a frame do not alter that frame. They take effect at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_ext | input | 1 | Tick source select: 0 internal, 1 external |
| tick_int | input | 1 | Internal baud tick, one-cycle pulse |
| ext_clk | input | 1 | External baud clock, asynchronous |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | One-cycle pulse when the holding byte moves to the shift register |
| tx_done | output | 1 | One-cycle pulse when a frame ends with nothing queued |

## Verification
Every output is registered. After the write edge, `buf_empty` is due one edge later, so the bench samples it on the second falling clock after the write. The start bit falls on a divider wrap, which can land anywhere in a 16-tick window. The bench therefore measures this latency as a range, and from the first low sample it counts clocks so that it can sample each bit at mid-period (32 + 64·k clocks with the internal tick, twice that with the external clock). At exactly one bit period times the frame length, the bench checks `tx_done`, `buf_empty` and the line level. It also confirms that `tx_done` is still 0 one clock earlier.

// File: rtl/dbuf_uart_pkg.sv
package dbuf_uart_pkg;

  localparam int MAX_BITS = 8;
  localparam int FRAME_W  = MAX_BITS + 3;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHIFT} tx_state_e;

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
  } frame_cfg_t;

  // Number of line bits in one frame: start + data + parity + stop
  function automatic logic [3:0] frame_bits(frame_cfg_t c);
    int n;
    n = 2 + (c.len8 ? MAX_BITS : MAX_BITS - 1) + (c.par_en ? 1 : 0);
    return 4'(n);
  endfunction

  // Frame image, bit 0 leaves first; unused upper bits stay 1 (stop/idle)
  function automatic logic [FRAME_W-1:0] build_frame(logic [MAX_BITS-1:0] d, frame_cfg_t c);
    logic [FRAME_W-1:0] f;
    int len;
    logic p;
    len  = c.len8 ? MAX_BITS : MAX_BITS - 1;
    f    = '1;
    f[0] = 1'b0;
    p    = c.par_odd;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < len) begin
        f[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    if (c.par_en) f[len+1] = p;
    return f;
  endfunction

endpackage

// File: rtl/dbuf_tick_sel.sv
module dbuf_tick_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src_ext,
  input  logic tick_int,
  input  logic ext_clk,
  output logic tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_tick = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign tick     = src_ext ? ext_tick : tick_int;

  // R2: an external edge yields a single-cycle tick
  p_ext_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    ext_tick |=> !ext_tick);

endmodule

// File: rtl/dbuf_baud_div.sv
module dbuf_baud_div #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic bit_stb
);

  localparam int CW = $clog2(TICKS_PER_BIT);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_stb = tick && (cnt_q == LAST);

  // R2: counter wraps to zero after the last tick of a bit
  p_div_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> (cnt_q == '0));

  // R2: counter holds between ticks
  p_div_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/dbuf_tx_shifter.sv
module dbuf_tx_shifter
  import dbuf_uart_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [MAX_BITS-1:0] wr_data,
  input  frame_cfg_t          cfg,
  input  logic                bit_stb,
  output logic                txd,
  output logic                buf_empty,
  output logic                tx_done
);

  tx_state_e           state_q;
  logic                hold_full_q;
  logic [MAX_BITS-1:0] hold_data_q;
  logic [FRAME_W-1:0]  frame_q;
  logic [3:0]          left_q;
  logic                txd_q, be_q, done_q;

  logic [FRAME_W-1:0]  next_frame;
  logic [3:0]          next_len;
  logic                idle_load, frame_end, chain_ev, load_ev;

  always_comb begin
    next_frame = build_frame(hold_data_q, cfg);
    next_len   = frame_bits(cfg);
  end

  assign idle_load = (state_q == ST_IDLE) && hold_full_q;
  assign frame_end = (state_q == ST_SHIFT) && bit_stb && (left_q == '0);
  assign chain_ev  = frame_end && hold_full_q;
  assign load_ev   = idle_load || chain_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      hold_full_q <= 1'b0;
      hold_data_q <= '0;
      frame_q     <= '1;
      left_q      <= '0;
      txd_q       <= 1'b1;
      be_q        <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      be_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (hold_full_q) begin
            frame_q <= next_frame;
            left_q  <= next_len - 4'd1;
            be_q    <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (bit_stb) begin
            txd_q   <= frame_q[0];
            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (bit_stb) begin
            if (left_q != '0) begin
              txd_q   <= frame_q[0];
              frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
              left_q  <= left_q - 4'd1;
            end else if (hold_full_q) begin
              txd_q   <= next_frame[0];
              frame_q <= {1'b1, next_frame[FRAME_W-1:1]};
              left_q  <= next_len - 4'd1;
              be_q    <= 1'b1;
            end else begin
              txd_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (load_ev) hold_full_q <= 1'b0;
      if (wr_en) begin
        hold_full_q <= 1'b1;
        hold_data_q <= wr_data;
      end
    end
  end

  assign txd       = txd_q;
  assign buf_empty = be_q;
  assign tx_done   = done_q;

  // R4: buffer-empty lasts one clock
  p_be_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    be_q |=> !be_q);
  // R4: a load from idle is followed by the buffer-empty pulse
  p_idle_load_be_r4: assert property (@(posedge clk) disable iff (rst)
    idle_load |=> be_q);
  // R8: transmit-complete lasts one clock, line high
  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_done_line_high_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> txd_q);
  // R7: a chained load never raises transmit-complete
  p_chain_no_done_r7: assert property (@(posedge clk) disable iff (rst)
    chain_ev |=> (be_q && !done_q && !txd_q));
  // R1: line is high while idle
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> txd_q);
  // R3: line only moves on a bit strobe
  p_edge_on_stb_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(txd_q) |-> $past(bit_stb));

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
  import dbuf_uart_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       src_ext,
  input  logic       tick_int,
  input  logic       ext_clk,
  input  logic       cfg_len8,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       buf_empty,
  output logic       tx_done
);

  logic       tick;
  logic       bit_stb;
  frame_cfg_t cfg;

  assign cfg = '{len8: cfg_len8, par_en: cfg_par_en, par_odd: cfg_par_odd};

  dbuf_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .src_ext(src_ext), .tick_int(tick_int),
    .ext_clk(ext_clk), .tick(tick)
  );

  dbuf_baud_div #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_div (
    .clk(clk), .rst(rst), .tick(tick), .bit_stb(bit_stb)
  );

  dbuf_tx_shifter u_shift (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .cfg(cfg),
    .bit_stb(bit_stb), .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  // R1: no status pulse and line high right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (txd && !buf_empty && !tx_done));

endmodule

// File: tb/tb_dbuf_uart_tx.sv
`timescale 1ns/1ps
module tb_dbuf_uart_tx;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_ext = 1'b0, tick_int = 1'b0, ext_clk = 1'b0;
  logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, buf_empty, tx_done;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  dbuf_uart_tx dut (
    .clk(clk), .rst(rst), .src_ext(src_ext), .tick_int(tick_int),
    .ext_clk(ext_clk), .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  // internal tick every 4 clocks -> 64 clocks per bit
  initial forever begin
    repeat (3) @(negedge clk);
    tick_int = 1'b1;
    @(negedge clk);
    tick_int = 1'b0;
  end
  // external clock, rising every 8 clocks -> 128 clocks per bit
  initial forever begin
    repeat (4) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  // {par_odd, par_en, len8, data}
  localparam logic [10:0] VEC [0:5] = '{
    {3'b001, 8'h00}, {3'b011, 8'hFF}, {3'b111, 8'hA5},
    {3'b000, 8'hDA}, {3'b010, 8'h7F}, {3'b110, 8'h81}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic set_cfg(input logic l8, input logic pe, input logic po);
    cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = po;
  endtask

  // Receive one frame; returns at the clock where the stop bit has ended
  task automatic rx(input logic [7:0] d, input logic l8, input logic pe, input logic po,
                    input int per, input bit wait_fall, input bit exp_done,
                    output int waited);
    logic exp_bits [0:10];
    int n, ones, c, target;
    waited = 0;
    if (wait_fall) begin
      do begin
        @(negedge clk);
        waited++;
      end while (txd !== 1'b0 && waited < 5000);
    end
    n = 0; ones = 0;
    exp_bits[n++] = 1'b0;
    for (int i = 0; i < (l8 ? 8 : 7); i++) begin
      exp_bits[n++] = d[i];
      ones += int'(d[i]);
    end
    if (pe) exp_bits[n++] = po ? ~ones[0] : ones[0];
    exp_bits[n++] = 1'b1;
    c = 0;
    for (int k = 0; k < n; k++) begin
      target = per / 2 + per * k;
      while (c < target) begin @(negedge clk); c++; end
      check(txd === exp_bits[k], $sformatf("R5/R6 bit%0d", k), int'(txd), int'(exp_bits[k]));
    end
    while (c < per * n - 1) begin @(negedge clk); c++; end
    check(tx_done === 1'b0, "R8 early done", int'(tx_done), 0);
    @(negedge clk);
    check(tx_done === exp_done, "R8/R7 done at frame end", int'(tx_done), int'(exp_done));
    if (exp_done) check(txd === 1'b1, "R8 line high", int'(txd), 1);
  endtask

  initial begin
    repeat (10000000) @(posedge clk);
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w;
    bit bad;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(txd === 1'b1, "R1 txd", int'(txd), 1);
    check(buf_empty === 1'b0, "R1 buf_empty", int'(buf_empty), 0);
    check(tx_done === 1'b0, "R1 tx_done", int'(tx_done), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Table of single frames (R3, R4, R5, R6, R8)
    foreach (VEC[i]) begin
      set_cfg(VEC[i][8], VEC[i][9], VEC[i][10]);
      do_write(VEC[i][7:0]);
      @(negedge clk);
      check(buf_empty === 1'b1, "R4 buf_empty after write", int'(buf_empty), 1);
      check(txd === 1'b1, "R3 not started yet", int'(txd), 1);
      rx(VEC[i][7:0], VEC[i][8], VEC[i][9], VEC[i][10], 64, 1'b1, 1'b1, w);
      check((w + 2 >= 3) && (w + 2 <= 65), "R3 start latency", w + 2, 65);
      repeat (7) @(negedge clk);
    end

    // Back-to-back with config change mid-frame (R7, R10)
    set_cfg(1'b1, 1'b1, 1'b0);
    do_write(8'h3C);
    fork
      rx(8'h3C, 1'b1, 1'b1, 1'b0, 64, 1'b1, 1'b0, w);
      begin
        repeat (300) @(negedge clk);
        set_cfg(1'b0, 1'b1, 1'b1);
        do_write(8'hC3);
      end
    join
    check(buf_empty === 1'b1, "R7 buf_empty at chain", int'(buf_empty), 1);
    check(txd === 1'b0, "R7 start follows stop", int'(txd), 0);
    rx(8'hC3, 1'b0, 1'b1, 1'b1, 64, 1'b0, 1'b1, w);
    repeat (5) @(negedge clk);

    // Overwrite of pending byte (R9)
    set_cfg(1'b1, 1'b0, 1'b0);
    do_write(8'h11);
    fork
      rx(8'h11, 1'b1, 1'b0, 1'b0, 64, 1'b1, 1'b0, w);
      begin
        repeat (150) @(negedge clk);
        do_write(8'h22);
        repeat (100) @(negedge clk);
        do_write(8'h33);
      end
    join
    check(buf_empty === 1'b1, "R9 chain load", int'(buf_empty), 1);
    rx(8'h33, 1'b1, 1'b0, 1'b0, 64, 1'b0, 1'b1, w);
    bad = 1'b0;
    repeat (800) begin
      @(negedge clk);
      if (txd !== 1'b1 || buf_empty !== 1'b0) bad = 1'b1;
    end
    check(!bad, "R9 overwritten byte not sent", int'(bad), 0);

    // External tick source (R2)
    src_ext = 1'b1;
    set_cfg(1'b1, 1'b1, 1'b1);
    do_write(8'h96);
    @(negedge clk);
    check(buf_empty === 1'b1, "R2 buf_empty ext", int'(buf_empty), 1);
    rx(8'h96, 1'b1, 1'b1, 1'b1, 128, 1'b1, 1'b1, w);
    src_ext = 1'b0;
    repeat (5) @(negedge clk);

    // Reset mid-frame (R1)
    do_write(8'h0F);
    rx(8'h0F, 1'b1, 1'b1, 1'b1, 64, 1'b1, 1'b1, w);
    do_write(8'h00);
    while (txd !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    do_write(8'h55);
    rst = 1'b1;
    @(negedge clk);
    check(txd === 1'b1, "R1 txd after mid-frame reset", int'(txd), 1);
    @(negedge clk);
    rst = 1'b0;
    bad = 1'b0;
    repeat (1500) begin
      @(negedge clk);
      if (txd !== 1'b1 || buf_empty !== 1'b0 || tx_done !== 1'b0) bad = 1'b1;
    end
    check(!bad, "R1 quiet after reset", int'(bad), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule